// File: doc/BRIEF.md
# Per-Frame Reed-Solomon Parity Generator

This block adds forward error correction parity to an Ethernet frame without touching the frame itself. Frame bytes arrive one per clock on a valid/ready stream. Each accepted byte is forwarded unchanged and in the same cycle. The bytes are also fed into a systematic Reed-Solomon encoder over GF(256). The default code has 223 information symbols and 32 parity symbols per codeword, so it corrects up to 16 symbol errors per block.

The frame is cut into consecutive blocks of `K_DATA` bytes, and the last block may be shorter. A short block is encoded as a shortened codeword: its zero padding sits in the high-order positions, so the padding changes nothing and is never sent. The parity of every block is held in a small store. Directly after the last frame byte, the whole group is emitted: first block first, and the highest-degree symbol first within each block. While the group is being sent, the input is held off.

Both streams follow valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. During the data phase the output valid follows the input valid, and the input ready follows the output ready, so back-pressure reaches the source in the same cycle. During the parity phase, `in_ready` is low. A parity symbol that is offered stays stable until it is taken.

Top module: `rs_frame_parity_enc`

## Requirements
- R1: Every accepted frame byte appears on `out_data` in the same cycle, with `out_valid` high and `out_par` low, and its value is unchanged.
- R2: After the byte flagged `in_eof` is accepted, the block emits exactly ceil(L/K_DATA)·NPAR symbols with `out_par` high, L being the frame length. No input byte is accepted until the last of these symbols is taken.
- R3: For each block, the data bytes followed by that block's parity symbols form a polynomial (first byte = highest degree) that vanishes at α^0 … α^(NPAR-1). Here α is a root of x^8+x^4+x^3+x^2+1 (0x11D), and byte bit i is the coefficient of α^i.
- R4: A final block shorter than K_DATA gets the parity of the same block zero-padded in its high-order positions, and no padding byte is output.
- R5: Parity groups leave in block order. Within a group, the symbol of degree NPAR-1 comes first and the degree-0 symbol comes last.
- R6: `out_last` is high only on the final parity symbol of a frame.
- R7: While `out_ready` is low, nothing is accepted at the input, and an offered parity symbol keeps its value and stays valid.
- R8: After reset, `out_valid` is low with no input, and `in_ready` is high.
- R9: Frames of up to MAX_BLKS·K_DATA bytes are handled without losing parity. A frame whose length is an exact multiple of K_DATA gets no extra, empty block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output symbol offered |
| out_ready | input | 1 | Downstream takes the symbol |
| out_data | output | 8 | Frame byte or parity symbol |
| out_par | output | 1 | High when out_data is a parity symbol |
| out_last | output | 1 | Final parity symbol of the frame |

## Verification
The two functions that can fall in the same cycle are the closing of a full block and the end of the frame. When a frame length is an exact multiple of K_DATA, the last byte both fills its block and carries `in_eof`. The parity must then be stored once and the encoder cleared once. The bench sweeps every frame length from 1 to four blocks in a small configuration, so each length hits this case or its neighbours. Each case is judged by the count of parity symbols and by syndromes that the bench recomputes for every block.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [8:0] FIELD_POLY = 9'h11D;

  typedef enum logic { ENC_DATA, ENC_PARITY } enc_state_t;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rs_par_lfsr.sv
module rs_par_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic                  restart,
  input  logic                  close,
  input  logic [SYM_W-1:0]      din,
  output logic [NPAR*SYM_W-1:0] rem_next
);
  localparam int VW = NPAR * SYM_W;

  function automatic logic [VW-1:0] gen_coeffs();
    logic [SYM_W-1:0] g [NPAR+1];
    logic [SYM_W-1:0] root;
    logic [VW-1:0]    packed_g;
    for (int j = 0; j <= NPAR; j++) g[j] = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    for (int j = 0; j < NPAR; j++) packed_g[j*SYM_W +: SYM_W] = g[j];
    return packed_g;
  endfunction

  localparam logic [VW-1:0] GEN = gen_coeffs();

  logic [VW-1:0]    rem_q;
  logic [VW-1:0]    base;
  logic [SYM_W-1:0] fb;

  always_comb begin
    base = restart ? '0 : rem_q;
    fb   = din ^ base[(NPAR-1)*SYM_W +: SYM_W];
    rem_next[0 +: SYM_W] = gf_mul(fb, GEN[0 +: SYM_W]);
    for (int j = 1; j < NPAR; j++)
      rem_next[j*SYM_W +: SYM_W] = base[(j-1)*SYM_W +: SYM_W] ^ gf_mul(fb, GEN[j*SYM_W +: SYM_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rem_q <= '0;
    else if (shift) rem_q <= close ? '0 : rem_next;
  end

  // R4
  lfsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift && close |=> rem_q == '0);
endmodule

// File: rtl/rs_par_store.sv
module rs_par_store
  import rs_enc_pkg::*;
#(
  parameter int NPAR     = 32,
  parameter int MAX_BLKS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [NPAR*SYM_W-1:0] push_word,
  input  logic                  pop,
  output logic [SYM_W-1:0]      sym,
  output logic                  last_sym
);
  localparam int CW = $clog2(MAX_BLKS + 1);
  localparam int SW = (NPAR > 1) ? $clog2(NPAR) : 1;
  localparam int DEPTH = 2 ** CW;

  logic [NPAR*SYM_W-1:0] mem [DEPTH];
  logic [CW-1:0] wr_cnt;
  logic [CW-1:0] rd_blk;
  logic [SW-1:0] rd_sym;
  logic          sym_end;
  logic          blk_end;

  assign sym_end  = (rd_sym == SW'(NPAR - 1));
  assign blk_end  = (rd_blk == wr_cnt - CW'(1));
  assign last_sym = sym_end && blk_end;
  assign sym      = mem[rd_blk][(NPAR - 1 - int'(rd_sym)) * SYM_W +: SYM_W];

  always_ff @(posedge clk) begin
    if (push) mem[wr_cnt] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_blk <= '0;
      rd_sym <= '0;
    end else begin
      if (push) wr_cnt <= wr_cnt + CW'(1);
      if (pop) begin
        if (sym_end) begin
          rd_sym <= '0;
          if (blk_end) begin
            rd_blk <= '0;
            wr_cnt <= '0;
          end else begin
            rd_blk <= rd_blk + CW'(1);
          end
        end else begin
          rd_sym <= rd_sym + SW'(1);
        end
      end
    end
  end

  // R9
  store_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> wr_cnt < CW'(MAX_BLKS));
  // R2
  store_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> wr_cnt != '0);
endmodule

// File: rtl/rs_frame_parity_enc.sv
module rs_frame_parity_enc
  import rs_enc_pkg::*;
#(
  parameter int NPAR     = 32,
  parameter int K_DATA   = 223,
  parameter int MAX_BLKS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_par,
  output logic       out_last
);
  localparam int CNT_W = (K_DATA > 1) ? $clog2(K_DATA) : 1;

  enc_state_t            st;
  logic [CNT_W-1:0]      byte_cnt;
  logic [CNT_W-1:0]      blk_pos;
  logic                  take;
  logic                  blk_end;
  logic                  pop;
  logic [NPAR*SYM_W-1:0] rem_next;
  logic [SYM_W-1:0]      st_sym;
  logic                  st_last;

  assign in_ready  = (st == ENC_DATA) && out_ready;
  assign take      = in_valid && in_ready;
  assign blk_pos   = in_sof ? '0 : byte_cnt;
  assign blk_end   = take && (in_eof || blk_pos == CNT_W'(K_DATA - 1));
  assign pop       = (st == ENC_PARITY) && out_ready;

  assign out_valid = (st == ENC_DATA) ? in_valid : 1'b1;
  assign out_data  = (st == ENC_DATA) ? in_data : st_sym;
  assign out_par   = (st == ENC_PARITY);
  assign out_last  = (st == ENC_PARITY) && st_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ENC_DATA;
      byte_cnt <= '0;
    end else begin
      if (take) byte_cnt <= blk_end ? '0 : blk_pos + CNT_W'(1);
      if (take && in_eof) st <= ENC_PARITY;
      else if (pop && st_last) st <= ENC_DATA;
    end
  end

  rs_par_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift    (take),
    .restart  (in_sof),
    .close    (blk_end),
    .din      (in_data),
    .rem_next (rem_next)
  );

  rs_par_store #(.NPAR(NPAR), .MAX_BLKS(MAX_BLKS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (blk_end),
    .push_word (rem_next),
    .pop       (pop),
    .sym       (st_sym),
    .last_sym  (st_last)
  );

  // R1
  data_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> out_valid && !out_par && out_data == in_data);
  // R2
  parity_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eof |=> out_par && out_valid && !in_ready);
  // R6
  last_is_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_par && out_valid);
  // R7
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_par |=> out_valid && out_par && $stable(out_data));
  // R7
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);
endmodule

// File: tb/rs_frame_parity_enc_test.sv
module rs_frame_parity_enc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int KD = 5;
  localparam int MB = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_par, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_frame_parity_enc #(.NPAR(NP), .K_DATA(KD), .MAX_BLKS(MB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par(out_par), .out_last(out_last));

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    int p = 0;
    int x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x << 1;
      if (x & 256) x = x ^ 'h11D;
    end
    return 8'(p);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  logic [7:0] sent [64];
  logic [7:0] rdat [256];
  bit         rpar [256];
  bit         rlast [256];

  task automatic run_frame(input int f, input int len, input bit stall);
    int idx = 0, n = 0, t = 0;
    bit fin = 0;
    bit held = 0;
    logic [7:0] held_v = 0;
    int nb, ok, lastpos;
    for (int i = 0; i < len; i++) sent[i] = 8'((f * 37 + i * 11 + 1) & 255);
    while (!fin && t < 2000) begin
      @(negedge clk);
      t++;
      in_valid  = (idx < len);
      in_data   = (idx < len) ? sent[idx] : 8'h00;
      in_sof    = (idx == 0);
      in_eof    = (idx == len - 1);
      out_ready = stall ? ((t % 3) != 2) : 1'b1;
      #1;
      if (held) begin
        // R7: stalled parity symbol held
        check(out_valid && out_par && out_data == held_v, "R7", out_data, held_v);
      end
      held = 0;
      if (!out_ready) begin
        // R7: no input taken during stall
        check(!in_ready, "R7", in_ready, 0);
        if (out_valid && out_par) begin held = 1; held_v = out_data; end
      end
      if (out_par && out_valid) begin
        // R2: input blocked in parity phase
        check(!in_ready, "R2", in_ready, 0);
      end
      if (in_valid && in_ready) begin
        // R1: same-cycle unchanged forward
        check(out_valid && !out_par && out_data == in_data, "R1", out_data, in_data);
        idx++;
      end
      if (out_valid && out_ready) begin
        rdat[n] = out_data; rpar[n] = out_par; rlast[n] = out_last;
        n++;
        if (out_last) fin = 1;
      end
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    nb = (len + KD - 1) / KD;
    // R1: frame bytes first, unchanged
    ok = 1;
    for (int i = 0; i < len; i++) if (rpar[i] || rdat[i] != sent[i]) ok = 0;
    check(ok == 1, "R1", ok, 1);
    // R2 / R9: parity count, no extra block on exact multiples
    check(n == len + nb * NP, "R9", n - len, nb * NP);
    ok = 1;
    for (int i = len; i < n; i++) if (!rpar[i]) ok = 0;
    check(ok == 1, "R2", ok, 1);
    // R6: out_last only on final symbol
    lastpos = -1;
    for (int i = 0; i < n; i++) if (rlast[i]) begin
      if (lastpos < 0) lastpos = i; else lastpos = -2;
    end
    check(lastpos == n - 1, "R6", lastpos, n - 1);
    // R3 R4 R5: syndromes of each shortened codeword vanish
    for (int b = 0; b < nb; b++) begin
      int lo = b * KD;
      int hi = (lo + KD < len) ? lo + KD : len;
      logic [7:0] root = 8'h01;
      int bad = 0;
      for (int r = 0; r < NP; r++) begin
        logic [7:0] s = 8'h00;
        for (int i = lo; i < hi; i++) s = fmul(s, root) ^ sent[i];
        for (int j = 0; j < NP; j++) s = fmul(s, root) ^ rdat[len + b * NP + j];
        if (s != 0) bad++;
        root = fmul(root, 8'h02);
      end
      check(bad == 0, (hi - lo < KD) ? "R4" : "R3_R5", bad, 0);
    end
  endtask

  initial begin
    rst_n = 0;
    out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R8: reset state
    check(!out_valid, "R8", out_valid, 0);
    check(in_ready, "R8", in_ready, 1);
    for (int len = 1; len <= MB * KD; len++) run_frame(len, len, 1'b0);
    for (int len = 1; len <= MB * KD; len++) run_frame(len + 50, len, 1'b1);
    run_frame(99, KD * 2, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule